// File: doc/BRIEF.md
# Selectable-Order MASH Fractional Modulator

This block drives the instantaneous divide-value offset of a fractional-N frequency synthesizer. On every comparison-clock edge it adds a fractional word K to a cascade of first-order accumulators. It then merges their overflow bits through difference (noise-cancelling) paths into one small signed offset. The divider control adds that offset to the integer divide value, so the long-run divide ratio gains K/2^FRAC_W.

The cascade runs either with two stages (second-order noise shaping, offset from -1 to +2) or with three stages (third-order, offset from -3 to +4). The choice may change while the loop is locked. On a change, the stages after the first restart from zero so that no stale overflow history is merged. An optional dither input flips the least significant bit of the fraction on alternate cycles to break up idle tones. A bypass input, used when the prescaler is out of the path, holds the offset at zero and clears the modulator.

Top module: `mash_mod`

## Requirements
- R1: With a constant fraction K, dither off, no bypass and no order change since reset, any 4*2^FRAC_W consecutive offsets taken after the first 4*2^FRAC_W add up to exactly 4*K, for both orders. The offset average is therefore K/2^FRAC_W. FRAC_W defaults to 18.
- R2: While `order2_i` is 1 (two-stage mode), every offset is within -1..+2.
- R3: While `order2_i` is 0 (three-stage mode), every offset is within -3..+4.
- R4: From reset, with K = 0 and dither off, the offset stays 0.
- R5: While `bypass_i` is 1, the offset is 0 from the next edge onward and all modulator state is cleared. After release, the sequence is the same as after a reset, so R1 holds again.
- R6: With `dither_en_i` = 1, bit 0 of the fraction is XORed with a bit that starts at 0 and inverts every cycle. As a result, K = 0 gives nonzero offsets within 4*2^FRAC_W cycles.
- R7: On the edge where `order2_i` differs from its value at the previous edge, the second and third accumulators and all carry delay registers are cleared. The offset for that edge is the first-stage carry alone (0 or +1). After that, the range of the new mode applies.
- R8: While `rst_n` is 0, the offset is 0.
- R9: `ofs_o` is registered and reflects the inputs sampled at the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Comparison clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frac_i | input | FRAC_W | Fractional word K |
| order2_i | input | 1 | 1: two-stage (second order), 0: three-stage (third order) |
| dither_en_i | input | 1 | Enables the alternating LSB flip of the fraction |
| bypass_i | input | 1 | Prescaler bypassed: offset forced to 0, state cleared |
| ofs_o | output | 4 | Signed divide-value offset, two's complement |

## Verification
The hardest property to reach is the exact long-run average, R1. It only holds once the whole accumulator and delay state has entered its periodic regime, and 4*2^18 cycles is beyond any short run. The bench therefore runs a second instance with an 8-bit fraction. For each table entry it resets that instance, discards one full period of 1024 offsets and sums the next 1024, comparing the total with 4*K. Order changes are provoked on the full-width instance every few dozen cycles, so the one-cycle clear window and both range limits are exercised many times from different accumulator states.

// File: rtl/mash_pkg.sv
// Package: shared constants for the MASH fractional modulator.
// Assumes a fixed three-stage cascade; the offset width covers -3..+4.
package mash_pkg;
    localparam int NUM_STAGES = 3;
    localparam int OFS_W      = 4;
    typedef logic signed [OFS_W-1:0] ofs_t;
endpackage

// File: rtl/mash_acc_stage.sv
// Module: one first-order accumulator stage of the cascade.
// Adds add_i to the stored residue modulo 2^W, exposes the next residue
// (sum_o) and the overflow bit (carry_o). Assumes clr_i has priority over
// accumulation; clearing takes effect at the edge.
module mash_acc_stage #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic [W-1:0] add_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o,
    output logic [W-1:0] acc_o
);
    logic [W-1:0] acc_q;
    logic [W:0]   full;

    // Wide add: the extra bit is the overflow of the modulo-2^W sum.
    always_comb begin
        full    = {1'b0, acc_q} + {1'b0, add_i};
        sum_o   = full[W-1:0];
        carry_o = full[W];
    end

    // Residue register, cleared by reset or by the stage clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) acc_q <= '0;
        else                 acc_q <= sum_o;
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/mash_recomb.sv
// Module: noise-cancelling recombination of the stage carries.
// Computes c1 + (1-z^-1)c2 + (1-z^-1)^2 c3 into a registered signed offset.
// Assumes hold_i marks an order-change cycle: downstream terms are masked
// and delay history is cleared. The third term is dropped in two-stage mode.
module mash_recomb
    import mash_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_STAGES-1:0] cy_i,
    input  logic                  mode2_i,
    input  logic                  hold_i,
    input  logic                  bypass_i,
    output ofs_t                  ofs_o
);
    logic        c2_d1, c3_d1, c3_d2;
    logic [OFS_W-1:0] term1, term2, term3, total;
    ofs_t        ofs_q;

    // Carry delay line feeding the difference paths.
    always_ff @(posedge clk) begin
        if (!rst_n || bypass_i || hold_i) begin
            c2_d1 <= 1'b0;
            c3_d1 <= 1'b0;
            c3_d2 <= 1'b0;
        end else begin
            c2_d1 <= cy_i[1];
            c3_d1 <= cy_i[2];
            c3_d2 <= c3_d1;
        end
    end

    // Sum of the first carry and the masked first/second differences.
    always_comb begin
        term1 = OFS_W'(cy_i[0]);
        term2 = hold_i ? '0 : (OFS_W'(cy_i[1]) - OFS_W'(c2_d1));
        term3 = (hold_i || mode2_i) ? '0
              : (OFS_W'(cy_i[2]) - {{(OFS_W-2){1'b0}}, c3_d1, 1'b0} + OFS_W'(c3_d2));
        total = term1 + term2 + term3;
    end

    // Output register; forced to zero during reset and bypass.
    always_ff @(posedge clk) begin
        if (!rst_n || bypass_i) ofs_q <= '0;
        else                    ofs_q <= ofs_t'(total);
    end

    assign ofs_o = ofs_q;
endmodule

// File: rtl/mash_mod.sv
// Module: selectable-order MASH fractional modulator (top).
// Feeds the (optionally dithered) fraction into a three-stage accumulator
// cascade; stage n+1 accumulates the residue of stage n. In two-stage mode
// the third stage is held cleared. Assumes frac_i is held steady for long
// stretches; order changes restart the downstream stages.
module mash_mod
    import mash_pkg::*;
#(
    parameter int FRAC_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic              order2_i,
    input  logic              dither_en_i,
    input  logic              bypass_i,
    output logic signed [OFS_W-1:0] ofs_o
);
    localparam int NST = NUM_STAGES;

    logic              order_q;
    logic              tgl_q;
    logic              order_chg;
    logic [FRAC_W-1:0] k_eff;
    logic [FRAC_W-1:0] st_add [NST];
    logic [FRAC_W-1:0] st_sum [NST];
    logic [FRAC_W-1:0] st_acc [NST];
    logic [NST-1:0]    st_cy;
    logic [NST-1:0]    st_clr;
    ofs_t              rc_ofs;

    // Remembers the order seen at the previous edge to spot a change.
    always_ff @(posedge clk) begin
        if (!rst_n) order_q <= order2_i;
        else        order_q <= order2_i;
    end

    // Dither toggle: alternates while enabled, rests at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || bypass_i || !dither_en_i) tgl_q <= 1'b0;
        else                                    tgl_q <= ~tgl_q;
    end

    // Effective fraction and per-stage clear decode.
    always_comb begin
        order_chg = (order2_i != order_q);
        k_eff     = frac_i ^ {{(FRAC_W-1){1'b0}}, tgl_q};
        st_clr[0] = bypass_i;
        st_clr[1] = bypass_i | order_chg;
        st_clr[2] = bypass_i | order_chg | order2_i;
    end

    generate
        for (genvar g = 0; g < NST; g++) begin : g_stage
            if (g == 0) begin : g_head
                assign st_add[g] = k_eff;
            end else begin : g_tail
                assign st_add[g] = st_sum[g-1];
            end
            mash_acc_stage #(.W(FRAC_W)) u_stage (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr_i  (st_clr[g]),
                .add_i  (st_add[g]),
                .sum_o  (st_sum[g]),
                .carry_o(st_cy[g]),
                .acc_o  (st_acc[g])
            );
        end
    endgenerate

    mash_recomb u_recomb (
        .clk     (clk),
        .rst_n   (rst_n),
        .cy_i    (st_cy),
        .mode2_i (order2_i),
        .hold_i  (order_chg),
        .bypass_i(bypass_i),
        .ofs_o   (rc_ofs)
    );

    assign ofs_o = rc_ofs;

    // R2: two-stage mode keeps the offset within -1..+2
    a_r2_range_two: assert property (@(posedge clk) disable iff (!rst_n)
        (order2_i && order_q && !bypass_i) |=> (ofs_o >= -1 && ofs_o <= 2));

    // R3: three-stage mode keeps the offset within -3..+4
    a_r3_range_three: assert property (@(posedge clk) disable iff (!rst_n)
        (!order2_i && !bypass_i) |=> (ofs_o >= -3 && ofs_o <= 4));

    // R5: bypass forces a zero offset and empties the first stage
    a_r5_bypass_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_i |=> (ofs_o == 0 && st_acc[0] == '0));

    // R7: an order change clears downstream stages; offset is c1 alone
    a_r7_switch_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (order_chg && !bypass_i) |=> (st_acc[1] == '0 && st_acc[2] == '0
                                      && ofs_o >= 0 && ofs_o <= 1));

    // R8: offset is zero on the edge following reset
    a_r8_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (ofs_o == 0));
endmodule

// File: tb/mash_mod_tb.sv
// Bench: a full-width instance for ranges, bypass and order changes, and
// an 8-bit instance for exact period sums (table driven).
module mash_mod_tb_top;
    localparam int SW   = 8;
    localparam int PER  = 4 * (1 << SW);
    localparam int NVEC = 10;
    localparam int TAB_ORD [NVEC] = '{1, 1, 1, 1, 1, 0, 0, 0, 0, 0};
    localparam int TAB_K   [NVEC] = '{0, 1, 77, 128, 255, 0, 1, 77, 200, 255};
    localparam int TAB_EXP [NVEC] = '{0, 4, 308, 512, 1020, 0, 4, 308, 800, 1020};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [17:0] m_frac = '0;
    logic        m_order = 1'b1, m_dith = 1'b0, m_byp = 1'b0;
    logic signed [3:0] m_ofs;
    logic [SW-1:0] s_frac = '0;
    logic        s_order = 1'b1, s_dith = 1'b0, s_byp = 1'b0;
    logic signed [3:0] s_ofs;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mash_mod dut_i (
        .clk(clk), .rst_n(rst_n), .frac_i(m_frac), .order2_i(m_order),
        .dither_en_i(m_dith), .bypass_i(m_byp), .ofs_o(m_ofs)
    );

    mash_mod #(.FRAC_W(SW)) dut_small_i (
        .clk(clk), .rst_n(rst_n), .frac_i(s_frac), .order2_i(s_order),
        .dither_en_i(s_dith), .bypass_i(s_byp), .ofs_o(s_ofs)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic small_window(output int total);
        for (int i = 0; i < PER; i++) step();
        total = 0;
        for (int i = 0; i < PER; i++) begin
            step();
            total += int'(s_ofs);
        end
    endtask

    task automatic range_run(input bit ord, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            step();
            if (ord) chk(m_ofs >= -1 && m_ofs <= 2, tag, int'(m_ofs), 2);
            else     chk(m_ofs >= -3 && m_ofs <= 4, tag, int'(m_ofs), 4);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int total;
        int nz;
        @(negedge clk);
        do_reset();

        // R8: dirty the state, then reset and look at the offset
        m_frac = 18'h2AAAB; m_order = 1'b0;
        range_run(1'b0, 200, "R3");
        rst_n = 1'b0;
        step();
        chk(m_ofs == 0, "R8 main", int'(m_ofs), 0);
        chk(s_ofs == 0, "R8 small", int'(s_ofs), 0);
        rst_n = 1'b1;

        // R1: exact period sums on the 8-bit instance, both orders
        for (int e = 0; e < NVEC; e++) begin
            s_order = TAB_ORD[e][0];
            s_frac  = SW'(TAB_K[e]);
            s_dith  = 1'b0;
            s_byp   = 1'b0;
            do_reset();
            small_window(total);
            chk(total == TAB_EXP[e], "R1 period sum", total, TAB_EXP[e]);
        end

        // R4: zero fraction, no dither, stays at zero
        m_frac = '0; m_order = 1'b0; m_dith = 1'b0;
        do_reset();
        nz = 0;
        for (int i = 0; i < 500; i++) begin
            step();
            if (m_ofs != 0) nz++;
        end
        chk(nz == 0, "R4 zero fraction", nz, 0);

        // R6: dither alone produces nonzero offsets on the small instance
        s_frac = '0; s_order = 1'b0; s_dith = 1'b1;
        do_reset();
        nz = 0;
        for (int i = 0; i < PER; i++) begin
            step();
            if (s_ofs != 0) nz++;
        end
        chk(nz > 0, "R6 dither activity", nz, 1);
        s_dith = 1'b0;

        // R2 / R3: range limits for several fractions on the full instance
        m_order = 1'b1; m_frac = 18'd1; do_reset();
        range_run(1'b1, 3000, "R2");
        m_order = 1'b1; m_frac = 18'h3FFFF; do_reset();
        range_run(1'b1, 3000, "R2");
        m_order = 1'b0; m_frac = 18'h1234F; do_reset();
        range_run(1'b0, 3000, "R3");
        m_order = 1'b0; m_frac = 18'h3FFF0; do_reset();
        range_run(1'b0, 3000, "R3");

        // R9: registered output; first edge after reset with K=1 gives 0
        m_order = 1'b1; m_frac = 18'd1; rst_n = 1'b0; step(); rst_n = 1'b1;
        step();
        chk(m_ofs == 0, "R9 first offset", int'(m_ofs), 0);

        // R7: order changes every 37 cycles from varied states
        m_frac = 18'h2AAAB; do_reset();
        for (int r = 0; r < 60; r++) begin
            m_order = ~m_order;
            step();
            chk(m_ofs >= 0 && m_ofs <= 1, "R7 change cycle", int'(m_ofs), 1);
            range_run(m_order, 36, "R7");
        end

        // R5: bypass forces zero on the full instance
        m_order = 1'b0; m_frac = 18'h30001;
        range_run(1'b0, 100, "R3");
        m_byp = 1'b1;
        nz = 0;
        for (int i = 0; i < 40; i++) begin
            step();
            if (m_ofs != 0) nz++;
        end
        chk(nz == 0, "R5 bypass zero", nz, 0);
        m_byp = 1'b0;

        // R5: after release the small instance restarts as from reset
        s_order = 1'b0; s_frac = SW'(77); do_reset();
        for (int i = 0; i < 300; i++) step();
        s_byp = 1'b1;
        for (int i = 0; i < 5; i++) step();
        chk(s_ofs == 0, "R5 small bypass", int'(s_ofs), 0);
        s_byp = 1'b0;
        small_window(total);
        chk(total == 308, "R5 restart sum", total, 308);

        finish_run();
    end
endmodule